// File: doc/BRIEF.md
# Min-Sum Check Node Dataset Unit

This block keeps the compressed state of a single parity check node for a serial min-sum LDPC decoder. It does not store one message per connected arc. It keeps a small dataset: the smallest magnitude seen, the second smallest, the arc index that supplied the smallest, and the XOR of all hard-decision signs. The unit holds two copies of this dataset. The *old* copy is frozen and comes from the previous iteration. The *running* copy is built up as each connected bit node is visited in the current iteration.

Queries are served from the old copy. A query gives an arc index and that arc's sign from the previous iteration. The unit answers at once with the check-to-bit message in sign-magnitude form. The magnitude is the second smallest value when the queried arc is the stored argmin, and the smallest value otherwise. The sign is the stored parity XORed with the queried sign. Updates go into the running copy. An end-of-iteration strobe moves the running copy into the old copy and restarts the accumulation.

The running side has a small controller with two states. `ST_OPEN` accepts arc updates and counts them. It moves to `ST_FULL` when the update that brings the count to `DEG` is accepted. `ST_FULL` ignores further updates. An end-of-iteration strobe returns either state to `ST_OPEN` and clears the count.

Top module: `cn_dataset_unit`

## Requirements
- R1: After reset, both copies hold magnitude code all-ones for the minimum and second minimum, argmin index 0 and parity 0, so every query returns magnitude all-ones with sign equal to `qry_sign`.
- R2: The output magnitude `msg_out[MAG_W-1:0]` is the old second minimum when `qry_idx` equals the old argmin index, and the old minimum otherwise.
- R3: The output sign `msg_out[MAG_W]` (the bit above the magnitude) is the old parity XOR `qry_sign`.
- R4: An accepted update whose magnitude is strictly below the running minimum moves the previous minimum into the second minimum and records the new magnitude and its `upd_idx` as the minimum and argmin.
- R5: An accepted update whose magnitude is not below the running minimum but is strictly below the running second minimum replaces the second minimum only. A tie with the minimum therefore leaves the argmin unchanged.
- R6: Each accepted update XORs `upd_sign` into the running parity.
- R7: On a clock edge with `iter_end` high, the old copy takes the running copy, and the running copy restarts at all-ones, all-ones, index 0, parity 0, with an arc count of zero.
- R8: An update presented in the same cycle as `iter_end` is dropped. It reaches neither copy.
- R9: Once `DEG` updates have been accepted in an iteration, later updates are ignored until the next `iter_end`.
- R10: An update with `upd_idx` not below `DEG` is ignored and is not counted toward the `DEG` limit.
- R11: Between two `iter_end` strobes the old copy, and hence every query result, is unchanged by updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Arc update strobe |
| upd_idx | input | IDX_W | Arc position of the update within the check node |
| upd_sign | input | 1 | Hard-decision sign of the bit-to-check message |
| upd_mag | input | MAG_W | Magnitude of the bit-to-check message |
| iter_end | input | 1 | End-of-iteration strobe: commit running copy, restart accumulation |
| qry_idx | input | IDX_W | Arc position being queried |
| qry_sign | input | 1 | Previous-iteration sign of the queried arc |
| msg_out | output | MAG_W+1 | Check-to-bit message, sign above magnitude |

## Verification
The bench builds the unit with `DEG` = 6 and `MAG_W` = 3. At these values all eight magnitude codes come up often, including the all-ones start value. Every query index, including the two that lie outside the node, is swept with both sign values after every commit. The arc-count limit is reached after only six updates, so the full-state drop and the out-of-range drop can be checked right next to ordinary iterations. Several hundred random iterations with repeated magnitudes cover ties at the minimum and at the second minimum.

// File: rtl/cn_ds_pkg.sv
package cn_ds_pkg;
    typedef enum logic [0:0] {
        ST_OPEN = 1'b0,
        ST_FULL = 1'b1
    } acc_state_e;
endpackage

// File: rtl/cn_run_acc.sv
module cn_run_acc
    import cn_ds_pkg::*;
#(
    parameter int DEG   = 30,
    parameter int MAG_W = 4,
    parameter int IDX_W = $clog2(DEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_sign,
    input  logic [MAG_W-1:0] upd_mag,
    input  logic             iter_end,
    output logic [MAG_W-1:0] run_min,
    output logic [MAG_W-1:0] run_smin,
    output logic [IDX_W-1:0] run_idx,
    output logic             run_par
);
    localparam int CNT_W = $clog2(DEG + 1);
    localparam logic [MAG_W-1:0] MAG_TOP = {MAG_W{1'b1}};
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DEG - 1);
    localparam logic [IDX_W:0] IDX_LIM = (IDX_W + 1)'(DEG);

    acc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             idx_ok;
    logic             accept;

    assign idx_ok = ({1'b0, upd_idx} < IDX_LIM);
    assign accept = upd_valid && !iter_end && (state_q == ST_OPEN) && idx_ok;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (accept && cnt_q == LAST_CNT) state_d = ST_FULL;
            end
            ST_FULL: begin
                if (iter_end) state_d = ST_OPEN;
            end
            default: state_d = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || iter_end) begin
            cnt_q    <= '0;
            run_min  <= MAG_TOP;
            run_smin <= MAG_TOP;
            run_idx  <= '0;
            run_par  <= 1'b0;
        end else if (accept) begin
            cnt_q   <= cnt_q + 1'b1;
            run_par <= run_par ^ upd_sign;
            if (upd_mag < run_min) begin
                run_smin <= run_min;
                run_min  <= upd_mag;
                run_idx  <= upd_idx;
            end else if (upd_mag < run_smin) begin
                run_smin <= upd_mag;
            end
        end
    end

    // R4 R5
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_min <= run_smin);

    // R9
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL && !iter_end) |=>
            ($stable(run_min) && $stable(run_smin) && $stable(run_idx) && $stable(run_par)));

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iter_end |=> (run_min == MAG_TOP && run_smin == MAG_TOP && run_idx == '0 && !run_par));

    // R10
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, run_idx} < IDX_LIM);
endmodule

// File: rtl/cn_old_store.sv
module cn_old_store #(
    parameter int DEG   = 30,
    parameter int MAG_W = 4,
    parameter int IDX_W = $clog2(DEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iter_end,
    input  logic [MAG_W-1:0] run_min,
    input  logic [MAG_W-1:0] run_smin,
    input  logic [IDX_W-1:0] run_idx,
    input  logic             run_par,
    output logic [MAG_W-1:0] old_min,
    output logic [MAG_W-1:0] old_smin,
    output logic [IDX_W-1:0] old_idx,
    output logic             old_par
);
    localparam logic [MAG_W-1:0] MAG_TOP = {MAG_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            old_min  <= MAG_TOP;
            old_smin <= MAG_TOP;
            old_idx  <= '0;
            old_par  <= 1'b0;
        end else if (iter_end) begin
            old_min  <= run_min;
            old_smin <= run_smin;
            old_idx  <= run_idx;
            old_par  <= run_par;
        end
    end

    // R11
    old_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iter_end |=> ($stable(old_min) && $stable(old_smin) && $stable(old_idx) && $stable(old_par)));

    // R7
    commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iter_end |=> (old_min == $past(run_min) && old_smin == $past(run_smin)
                      && old_par == $past(run_par)));
endmodule

// File: rtl/cn_msg_out.sv
module cn_msg_out #(
    parameter int DEG   = 30,
    parameter int MAG_W = 4,
    parameter int IDX_W = $clog2(DEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAG_W-1:0] old_min,
    input  logic [MAG_W-1:0] old_smin,
    input  logic [IDX_W-1:0] old_idx,
    input  logic             old_par,
    input  logic [IDX_W-1:0] qry_idx,
    input  logic             qry_sign,
    output logic [MAG_W:0]   msg_out
);
    logic hit;

    always_comb begin
        hit     = (qry_idx == old_idx);
        msg_out = {old_par ^ qry_sign, hit ? old_smin : old_min};
    end

    // R2
    msg_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_out[MAG_W-1:0] >= old_min);
endmodule

// File: rtl/cn_dataset_unit.sv
module cn_dataset_unit #(
    parameter int DEG   = 30,
    parameter int MAG_W = 4,
    parameter int IDX_W = $clog2(DEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_sign,
    input  logic [MAG_W-1:0] upd_mag,
    input  logic             iter_end,
    input  logic [IDX_W-1:0] qry_idx,
    input  logic             qry_sign,
    output logic [MAG_W:0]   msg_out
);
    logic [MAG_W-1:0] run_min, run_smin, old_min, old_smin;
    logic [IDX_W-1:0] run_idx, old_idx;
    logic             run_par, old_par;

    cn_run_acc #(.DEG(DEG), .MAG_W(MAG_W), .IDX_W(IDX_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_idx(upd_idx),
        .upd_sign(upd_sign), .upd_mag(upd_mag), .iter_end(iter_end),
        .run_min(run_min), .run_smin(run_smin), .run_idx(run_idx), .run_par(run_par)
    );

    cn_old_store #(.DEG(DEG), .MAG_W(MAG_W), .IDX_W(IDX_W)) u_old (
        .clk(clk), .rst_n(rst_n), .iter_end(iter_end),
        .run_min(run_min), .run_smin(run_smin), .run_idx(run_idx), .run_par(run_par),
        .old_min(old_min), .old_smin(old_smin), .old_idx(old_idx), .old_par(old_par)
    );

    cn_msg_out #(.DEG(DEG), .MAG_W(MAG_W), .IDX_W(IDX_W)) u_msg (
        .clk(clk), .rst_n(rst_n),
        .old_min(old_min), .old_smin(old_smin), .old_idx(old_idx), .old_par(old_par),
        .qry_idx(qry_idx), .qry_sign(qry_sign), .msg_out(msg_out)
    );
endmodule

// File: tb/tb_cn_dataset_unit.sv
module tb_cn_dataset_unit;
    localparam int DEG = 6;
    localparam int MW  = 3;
    localparam int IW  = $clog2(DEG);
    localparam int TOP = (1 << MW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          upd_valid = 1'b0;
    logic [IW-1:0] upd_idx = '0;
    logic          upd_sign = 1'b0;
    logic [MW-1:0] upd_mag = '0;
    logic          iter_end = 1'b0;
    logic [IW-1:0] qry_idx = '0;
    logic          qry_sign = 1'b0;
    logic [MW:0]   msg_out;

    int checks = 0;
    int errors = 0;

    // model of the accepted updates of the iteration being built, and of the committed one
    int m_mag[DEG];
    int m_idx[DEG];
    int m_n = 0;
    int m_par = 0;
    int e_min = TOP, e_smin = TOP, e_idx = 0, e_par = 0;

    always #2 clk = ~clk;

    cn_dataset_unit #(.DEG(DEG), .MAG_W(MW), .IDX_W(IW)) dut (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_idx(upd_idx),
        .upd_sign(upd_sign), .upd_mag(upd_mag), .iter_end(iter_end),
        .qry_idx(qry_idx), .qry_sign(qry_sign), .msg_out(msg_out)
    );

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // adds to the model only what the requirements say is accepted
    task automatic push(input int i, input int s, input int m, input bit model_take);
        upd_valid = 1'b1;
        upd_idx   = IW'(i);
        upd_sign  = s[0];
        upd_mag   = MW'(m);
        @(negedge clk);
        upd_valid = 1'b0;
        if (model_take) begin
            m_mag[m_n] = m;
            m_idx[m_n] = i;
            m_n++;
            m_par ^= s;
        end
    endtask

    // expected committed dataset: minimum over the list, first position holding it,
    // second minimum over every other entry; all start from the all-ones code
    task automatic commit();
        int p;
        iter_end = 1'b1;
        @(negedge clk);
        iter_end = 1'b0;
        e_min = TOP; p = -1;
        for (int k = 0; k < m_n; k++) if (m_mag[k] < e_min) begin e_min = m_mag[k]; p = k; end
        e_smin = TOP;
        for (int k = 0; k < m_n; k++) if (k != p && m_mag[k] < e_smin) e_smin = m_mag[k];
        e_idx = (p < 0) ? 0 : m_idx[p];
        e_par = m_par;
        m_n = 0;
        m_par = 0;
    endtask

    task automatic sweep(input string req);
        for (int q = 0; q < (1 << IW); q++) begin
            for (int s = 0; s < 2; s++) begin
                int exp_v;
                qry_idx  = IW'(q);
                qry_sign = s[0];
                #0.5;
                exp_v = ((e_par ^ s) << MW) | ((q == e_idx) ? e_smin : e_min);
                checks++;
                if (int'(msg_out) != exp_v) begin
                    errors++;
                    $display("FAIL %s q=%0d s=%0d actual=%0h expected=%0h", req, q, s, msg_out, exp_v);
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sweep("R1 reset state");

        // R4 R5: descending run, then tie with minimum must keep argmin
        push(2, 1, 5, 1); push(4, 0, 2, 1); push(0, 1, 2, 1);
        push(5, 0, 6, 1); push(1, 1, 3, 1); push(3, 0, 7, 1);
        commit();
        sweep("R4 R5 R6 tie at minimum");

        // R11: updates without commit leave queries unchanged
        push(1, 1, 0, 1); push(3, 1, 1, 1);
        sweep("R11 old copy held");
        commit();
        sweep("R2 R3 partial iteration");

        // R7: commit of an empty iteration gives the restart values
        commit();
        sweep("R7 empty iteration restart");

        // R9: extra updates after DEG accepted are dropped
        for (int k = 0; k < DEG; k++) push(k, k & 1, 4 + (k % 3), 1);
        push(2, 1, 0, 0); push(4, 1, 1, 0);
        commit();
        sweep("R9 arc limit");

        // R10: out-of-range index ignored and not counted
        push(DEG, 1, 0, 0); push(DEG + 1, 1, 0, 0);
        for (int k = 0; k < DEG; k++) push(DEG - 1 - k, 0, 3 + k % 2, 1);
        commit();
        sweep("R10 out-of-range index");

        // R8: update alongside commit is lost
        push(0, 1, 6, 1);
        upd_valid = 1'b1; upd_idx = IW'(3); upd_sign = 1'b1; upd_mag = '0;
        commit();
        upd_valid = 1'b0;
        sweep("R8 commit side");
        commit();
        sweep("R8 next iteration");

        // all-ones magnitudes keep argmin at 0
        for (int k = 0; k < DEG; k++) push(k, 1, TOP, 1);
        commit();
        sweep("R4 all-ones codes");

        // random iterations, magnitudes drawn from a narrow range to force ties
        for (int it = 0; it < 400; it++) begin
            int cnt;
            cnt = (it % 4 == 0) ? int'($urandom_range(0, DEG)) : DEG;
            for (int k = 0; k < cnt; k++) begin
                int mg;
                mg = (it % 2 == 0) ? int'($urandom_range(0, TOP)) : int'($urandom_range(2, 4));
                push(int'($urandom_range(0, DEG - 1)), int'($urandom_range(0, 1)), mg, 1);
            end
            commit();
            sweep("R2 R3 R4 R5 R6 R7 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule